// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the host-facing programming port of an 8-bit programmable interrupt controller. A host reaches it through two addresses, chosen by a single address bit, using separate read and write strobes. A write-sequence state machine steers writes on those two addresses. Depending on the sequence state and on bits of the written data, a write becomes one of four setup words, one of two runtime command words, or a new mask value.

The block holds three registers: the pending-request register, the in-service register and the mask register. The first two are sampled from external inputs on every clock. The mask is written by the host and also driven out to downstream priority logic. Reads on the even address return the request or in-service register, as chosen by a sticky pointer. Reads on the odd address return the mask.

The stored setup and runtime words are brought out as ports for the rest of the controller. A one-cycle error flag reports runtime commands that were refused. A busy flag shows that the setup sequence is still running.

Top module: `irq_cmd_port`

## Requirements
- R1: After a synchronous reset, mask_out, rd_data, all four setup words and the first runtime word are 0x00. The second runtime word is 0x02, init_busy and cmd_err are 0, and the even-address read pointer selects the request register.
- R2: A write to the even address (addr_sel=0) with data bit 4 set is a restart. In the next cycle cfg_w1 holds the data, mask_out is 0x00, op_w3 is 0x02, the read pointer selects the request register and init_busy is 1. This holds even while a sequence is already running.
- R3: After a restart, the next three odd-address writes are stored in order into cfg_w2, cfg_w3 and cfg_w4. init_busy stays 1 until the third of them has been taken, and drops in the cycle after it.
- R4: The third odd-address write after a restart updates cfg_w4 only if bit 0 of cfg_w1 is 1. Otherwise cfg_w4 keeps its old value, but the sequence still ends.
- R5: While init_busy is 0, an odd-address write loads mask_out in the next cycle. No other write changes the mask except a restart.
- R6: While init_busy is 0, an even-address write with data bit 4 clear is decoded on bit 3. Bit 3 = 0 loads op_w2 and bit 3 = 1 loads op_w3.
- R7: An even-address write with data bit 4 clear that arrives while init_busy is 1 is refused. op_w2, op_w3 and the read pointer are left unchanged, and cmd_err is 1 for exactly the next cycle.
- R8: Writing op_w3 with bits 1:0 = 10 points even-address reads at the request register. Bits 1:0 = 11 point them at the in-service register. Bits 1:0 = 00 or 01 leave the pointer as it was.
- R9: rd_data is registered. In the cycle after rd_en it shows the selected register for addr_sel=0, or the mask for addr_sel=1. It holds its value when rd_en is 0.
- R10: The request and in-service registers take req_in and isr_in on every clock. A read therefore returns the input value captured at the edge before the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Address bit: 0 even, 1 odd |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| req_in | input | 8 | Pending-request lines sampled each clock |
| isr_in | input | 8 | In-service lines sampled each clock |
| mask_out | output | 8 | Current mask register |
| init_busy | output | 1 | Setup sequence in progress |
| cmd_err | output | 1 | One-cycle flag for a refused runtime command |
| cfg_w1 | output | 8 | First setup word |
| cfg_w2 | output | 8 | Second setup word |
| cfg_w3 | output | 8 | Third setup word |
| cfg_w4 | output | 8 | Fourth setup word |
| op_w2 | output | 8 | First runtime command word |
| op_w3 | output | 8 | Second runtime command word (read pointer in bits 1:0) |

## Verification
The assertions take for granted that reset is held for at least one clock edge and that the strobes, address bit and data are never unknown while reset is low. The stimulus meets this: reset is applied for several cycles before any strobe, and all inputs start at zero. Inputs change only on the falling clock edge, so each strobe is seen by exactly one rising edge. Read and write strobes may be high in the same cycle; a read then returns the register contents from before that write, and the bench model follows the same order.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

  // data bit that marks a restart on the even address
  localparam int BIT_RESTART = 4;
  // data bit choosing between the two runtime words
  localparam int BIT_OPSEL   = 3;
  // bit of the first setup word enabling the fourth word
  localparam int BIT_W4EN    = 0;
  // pointer field in the second runtime word
  localparam int BIT_PTRLOAD = 1;
  localparam int BIT_PTRISR  = 0;
  // number of setup words that follow the restart word
  localparam int TAIL_WORDS  = 3;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_W2  = 2'd1,
    ST_W3  = 2'd2,
    ST_W4  = 2'd3
  } init_step_e;

endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          restart_hit,
  output logic          run_odd_wr,
  output logic [DW-1:0] cfg_w1,
  output logic [DW-1:0] cfg_w2,
  output logic [DW-1:0] cfg_w3,
  output logic [DW-1:0] cfg_w4
);

  init_step_e step_q;
  logic [DW-1:0] tail_q [TAIL_WORDS];
  logic          seq_wr;

  assign restart_hit = wr_en && !addr_sel && wr_data[BIT_RESTART];
  assign seq_wr      = wr_en && addr_sel && (step_q != ST_RUN) && !restart_hit;
  assign run_odd_wr  = wr_en && addr_sel && (step_q == ST_RUN);
  assign busy        = (step_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_RUN;
      cfg_w1 <= '0;
    end else if (restart_hit) begin
      step_q <= ST_W2;
      cfg_w1 <= wr_data;
    end else if (seq_wr) begin
      case (step_q)
        ST_W2:   step_q <= ST_W3;
        ST_W3:   step_q <= ST_W4;
        default: step_q <= ST_RUN;
      endcase
    end
  end

  // one storage slot per trailing word; the last one is gated by the enable bit
  for (genvar g = 0; g < TAIL_WORDS; g++) begin : g_tail
    logic gate;
    if (g == TAIL_WORDS - 1) begin : g_last
      assign gate = cfg_w1[BIT_W4EN];
    end else begin : g_mid
      assign gate = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        tail_q[g] <= '0;
      end else if (seq_wr && (step_q == init_step_e'(g + 1)) && gate) begin
        tail_q[g] <= wr_data;
      end
    end
  end

  assign cfg_w2 = tail_q[0];
  assign cfg_w3 = tail_q[1];
  assign cfg_w4 = tail_q[2];

  // R2
  restart_start_chk: assert property (@(posedge clk) disable iff (rst)
    restart_hit |=> (busy && cfg_w1 == $past(wr_data)));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !restart_hit && !(wr_en && addr_sel)) |=> busy);

  // R4
  w4_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_wr && step_q == ST_W4 && !cfg_w1[BIT_W4EN]) |=> ($stable(cfg_w4) && !busy));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask_q <= '0;
    end else if (ld) begin
      mask_q <= din;
    end
  end

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mask_q == '0));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld) |=> $stable(mask_q));

endmodule

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic          restart_hit,
  output logic [DW-1:0] op_w2,
  output logic [DW-1:0] op_w3,
  output logic          sel_isr,
  output logic          cmd_err
);

  localparam logic [DW-1:0] OP3_INIT = DW'(2'b10);

  logic even_op, op_ok, op_bad, ld_w2, ld_w3;

  assign even_op = wr_en && !addr_sel && !wr_data[BIT_RESTART];
  assign op_bad  = even_op && busy;
  assign op_ok   = even_op && !busy;
  assign ld_w2   = op_ok && !wr_data[BIT_OPSEL];
  assign ld_w3   = op_ok &&  wr_data[BIT_OPSEL];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_w2   <= '0;
      op_w3   <= OP3_INIT;
      sel_isr <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= op_bad;
      if (restart_hit) begin
        op_w3   <= OP3_INIT;
        sel_isr <= 1'b0;
      end else begin
        if (ld_w2) op_w2 <= wr_data;
        if (ld_w3) begin
          op_w3 <= wr_data;
          if (wr_data[BIT_PTRLOAD]) sel_isr <= wr_data[BIT_PTRISR];
        end
      end
    end
  end

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(wr_en && !addr_sel && busy));

  // R7
  err_noop_chk: assert property (@(posedge clk) disable iff (rst)
    op_bad |=> ($stable(op_w2) && $stable(op_w3) && $stable(sel_isr) && cmd_err));

  // R8
  ptr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_w3 && !wr_data[BIT_PTRLOAD]) |=> $stable(sel_isr));

endmodule

// File: rtl/irq_readback.sv
module irq_readback #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          addr_sel,
  input  logic [DW-1:0] req_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] mask_q,
  input  logic          sel_isr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] req_q, isr_q, even_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      isr_q <= '0;
    end else begin
      req_q <= req_in;
      isr_q <= isr_in;
    end
  end

  assign even_sel = sel_isr ? isr_q : req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= addr_sel ? mask_q : even_sel;
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R10
  rd_req_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr_sel && !sel_isr) |=> (rd_data == $past(req_q)));

  // R9
  rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_sel) |=> (rd_data == $past(mask_q)));

endmodule

// File: rtl/irq_cmd_port.sv
module irq_cmd_port
  import irq_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] req_in,
  input  logic [DW-1:0] isr_in,
  output logic [DW-1:0] mask_out,
  output logic          init_busy,
  output logic          cmd_err,
  output logic [DW-1:0] cfg_w1,
  output logic [DW-1:0] cfg_w2,
  output logic [DW-1:0] cfg_w3,
  output logic [DW-1:0] cfg_w4,
  output logic [DW-1:0] op_w2,
  output logic [DW-1:0] op_w3
);

  logic restart_hit, run_odd_wr, busy, sel_isr;
  logic [DW-1:0] mask_q;

  irq_init_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr_sel    (addr_sel),
    .wr_data     (wr_data),
    .busy        (busy),
    .restart_hit (restart_hit),
    .run_odd_wr  (run_odd_wr),
    .cfg_w1      (cfg_w1),
    .cfg_w2      (cfg_w2),
    .cfg_w3      (cfg_w3),
    .cfg_w4      (cfg_w4)
  );

  irq_mask_reg #(.DW(DW)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart_hit),
    .ld     (run_odd_wr),
    .din    (wr_data),
    .mask_q (mask_q)
  );

  irq_op_decode #(.DW(DW)) u_op (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr_sel    (addr_sel),
    .wr_data     (wr_data),
    .busy        (busy),
    .restart_hit (restart_hit),
    .op_w2       (op_w2),
    .op_w3       (op_w3),
    .sel_isr     (sel_isr),
    .cmd_err     (cmd_err)
  );

  irq_readback #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr_sel (addr_sel),
    .req_in   (req_in),
    .isr_in   (isr_in),
    .mask_q   (mask_q),
    .sel_isr  (sel_isr),
    .rd_data  (rd_data)
  );

  assign mask_out  = mask_q;
  assign init_busy = busy;

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_busy) |-> $past(wr_en && addr_sel));

endmodule

// File: tb/test_irq_cmd_port.sv
`timescale 1ns/1ps
module test_irq_cmd_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, req_in = '0, isr_in = '0;
  logic [7:0] rd_data, mask_out, cfg_w1, cfg_w2, cfg_w3, cfg_w4, op_w2, op_w3;
  logic       init_busy, cmd_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_cmd_port i_irq_cmd_port (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .req_in(req_in), .isr_in(isr_in),
    .mask_out(mask_out), .init_busy(init_busy), .cmd_err(cmd_err),
    .cfg_w1(cfg_w1), .cfg_w2(cfg_w2), .cfg_w3(cfg_w3), .cfg_w4(cfg_w4),
    .op_w2(op_w2), .op_w3(op_w3)
  );

  // behavioural reference model
  int         m_step;
  logic [7:0] m_w [1:4];
  logic [7:0] m_mask, m_req, m_isr, m_op2, m_op3, m_rd;
  bit         m_ptr_isr, m_err;

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_mask = 0; m_req = 0; m_isr = 0; m_op2 = 0; m_op3 = 8'h02;
      m_rd = 0; m_ptr_isr = 0; m_err = 0;
      for (int i = 1; i <= 4; i++) m_w[i] = 0;
    end else begin
      if (rd_en) m_rd = addr_sel ? m_mask : (m_ptr_isr ? m_isr : m_req);
      m_err = 0;
      if (wr_en && !addr_sel && wr_data[4]) begin
        m_w[1] = wr_data; m_mask = 0; m_ptr_isr = 0; m_op3 = 8'h02; m_step = 2;
      end else if (wr_en && !addr_sel) begin
        if (m_step != 0) m_err = 1;
        else if (!wr_data[3]) m_op2 = wr_data;
        else begin
          m_op3 = wr_data;
          if (wr_data[1]) m_ptr_isr = wr_data[0];
        end
      end else if (wr_en && addr_sel) begin
        if (m_step == 0) m_mask = wr_data;
        else begin
          if (m_step < 4 || m_w[1][0]) m_w[m_step] = wr_data;
          m_step = (m_step == 4) ? 0 : m_step + 1;
        end
      end
      m_req = req_in; m_isr = isr_in;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 rd_data", rd_data, m_rd);
      chk("R5 mask_out", mask_out, m_mask);
      chk("R3 init_busy", {7'd0, init_busy}, {7'd0, m_step != 0});
      chk("R7 cmd_err", {7'd0, cmd_err}, {7'd0, m_err});
      chk("R2 cfg_w1", cfg_w1, m_w[1]);
      chk("R3 cfg_w2", cfg_w2, m_w[2]);
      chk("R3 cfg_w3", cfg_w3, m_w[3]);
      chk("R4 cfg_w4", cfg_w4, m_w[4]);
      chk("R6 op_w2", op_w2, m_op2);
      chk("R6 op_w3", op_w3, m_op3);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr_sel = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr_sel = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog got=hang exp=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask_out, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 op_w3", op_w3, 8'h02);
    chk("R1 busy", {7'd0, init_busy}, 8'h00);

    // R10 request sampled, read on even address
    req_in = 8'hA5; isr_in = 8'h3C;
    repeat (2) @(negedge clk);
    rd(1'b0);
    chk("R10 read request", rd_data, 8'hA5);

    // R5 mask load outside setup
    wr(1'b1, 8'h77);
    chk("R5 mask load", mask_out, 8'h77);

    // R2 restart with fourth word enabled
    wr(1'b0, 8'h13);
    chk("R2 mask cleared", mask_out, 8'h00);
    chk("R2 busy", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    chk("R3 still busy", {7'd0, init_busy}, 8'h01);
    wr(1'b0, 8'h0B);
    chk("R7 err pulse", {7'd0, cmd_err}, 8'h01);
    chk("R7 op_w3 unchanged", op_w3, 8'h02);
    @(negedge clk);
    chk("R7 err one cycle", {7'd0, cmd_err}, 8'h00);
    wr(1'b1, 8'h01);
    chk("R3 cfg_w3", cfg_w3, 8'h04);
    chk("R4 cfg_w4 stored", cfg_w4, 8'h01);
    chk("R3 busy done", {7'd0, init_busy}, 8'h00);

    // R6 and R8 runtime words and read pointer
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h20);
    chk("R6 op_w2", op_w2, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk("R8 select in-service", rd_data, 8'h3C);
    wr(1'b0, 8'h08);
    rd(1'b0);
    chk("R8 pointer kept on 00", rd_data, 8'h3C);
    wr(1'b0, 8'h09);
    rd(1'b0);
    chk("R8 pointer kept on 01", rd_data, 8'h3C);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R8 select request", rd_data, 8'hA5);
    rd(1'b1);
    chk("R9 odd read mask", rd_data, 8'hF0);
    repeat (3) @(negedge clk);
    chk("R9 rd_data held", rd_data, 8'hF0);

    // R4 restart without fourth word
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h11);
    wr(1'b1, 8'h22);
    wr(1'b1, 8'h33);
    chk("R4 cfg_w4 kept", cfg_w4, 8'h01);
    chk("R4 sequence ended", {7'd0, init_busy}, 8'h00);
    wr(1'b1, 8'h5A);
    chk("R5 mask after setup", mask_out, 8'h5A);

    // mixed traffic checked by the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wr_en    = ($urandom % 3) == 0;
      rd_en    = ($urandom % 3) == 0;
      addr_sel = $urandom % 2;
      wr_data  = 8'($urandom);
      if (wr_data[4] && ($urandom % 4) != 0) wr_data[4] = 1'b0;
      req_in   = 8'($urandom);
      isr_in   = 8'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule